// File: doc/BRIEF.md
# Interrupt Entry and Reset Vector Sequencer

This block is the control slice of an 8-bit accumulator-style processor core that owns everything between instructions: it brings the core out of reset, decides at each instruction boundary whether the next instruction may start or whether a non-maskable or maskable interrupt must be entered first, and runs the interrupt entry itself. Entry saves the return address and the status byte on the stack, masks further maskable requests and fetches a 16-bit handler address from a fixed vector location, low byte first. It also holds the status byte and the stack pointer, and carries out single-byte stack pushes and pulls on behalf of the core.

The core keeps the program counter and tells this block three things. It signals when it has reached an instruction boundary. It pulses `cli_exec` while it executes the clear-interrupt-mask instruction. It presents the peeked next opcode on `next_op`. The block answers with `issue`, which allows the next instruction to start, and with `pc_load`/`pc_vec`, which redirect the program counter after reset or interrupt entry. Memory is a byte-wide synchronous port: an address presented in one cycle returns its read data in the following cycle. A bus-request input freezes instruction issue and interrupt entry for as long as it is held.

Top module: `irqvec_sequencer`

## Requirements
- R1: While reset is low the status byte becomes 0x36 (bit 5 unused, bit 4 break, bit 2 mask I, bit 1 zero set; bits 7, 6 and 0 clear), except that bit 3 (decimal) keeps its previous value. The stack pointer becomes 0xFD. The latched NMI edge, the sampled IRQ level and the one-instruction CLI deferral are cleared.
- R2: After reset is released the block reads address 0xFFFC, then 0xFFFD. It then asserts `pc_load` for exactly one cycle, the third cycle after release, with `pc_vec` = {byte from 0xFFFD, byte from 0xFFFC}.
- R3: The IRQ line (`irq_n` low, sampled into a register) is taken at an instruction boundary only while status bit 2 is clear. Entry uses vector 0xFFFE/0xFFFF.
- R4: A falling edge on `nmi_n` is latched, even if the pulse ends before the boundary. It is taken regardless of status bit 2, has priority over IRQ, uses vector 0xFFFA/0xFFFB, and is taken once per edge even when the line stays low.
- R5: Interrupt entry lasts 7 cycles, from the cycle after the accepting boundary to the `pc_load` cycle inclusive. It writes the PC high byte at {0x01,S}, the PC low byte at {0x01,S-1} and the status byte with bit 5 set and bit 4 clear at {0x01,S-2}. It leaves S-3 in the stack pointer and sets status bit 2. The stack never leaves page 0x01.
- R6: When `cli_exec` pulses while the IRQ level is sampled active and bit 2 is set, bit 2 clears, the next boundary still issues one instruction, and the IRQ is taken at the boundary after it. Without an active IRQ at the CLI, a later IRQ is taken at the first boundary.
- R7: If `next_op` equals 0x40 (return-from-interrupt) when `cli_exec` pulses, no deferral is set and a pending IRQ is taken at the very next boundary.
- R8: While `busreq` is high, `issue` stays low and no interrupt entry starts, with no memory write and no stack pointer change. The pending request is served once `busreq` falls.
- R9: A core push writes `stk_wdata` at {0x01,S} and then decrements S. A core pull increments S, reads {0x01,S+1}, and the byte is on `mem_rdata` in the following cycle.
- R10: `issue` is high only in an idle boundary cycle with `busreq` low and no interrupt to take.
- R11: `p_we` loads `p_wdata` into the status byte, which appears on `status` after the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_n | input | 1 | Maskable interrupt request, active low, level |
| nmi_n | input | 1 | Non-maskable interrupt request, active low, edge |
| busreq | input | 1 | Bus request; holds off issue and interrupt entry |
| boundary | input | 1 | Core is at an instruction boundary |
| cli_exec | input | 1 | Pulse: clear-interrupt-mask instruction executing |
| next_op | input | 8 | Peeked next opcode byte |
| pc_cur | input | 16 | Current program counter from the core |
| p_we | input | 1 | Status byte write enable from the core |
| p_wdata | input | 8 | Status byte write data |
| stk_push | input | 1 | Core requests one stack push |
| stk_pull | input | 1 | Core requests one stack pull |
| stk_wdata | input | 8 | Byte to push |
| mem_addr | output | 16 | Memory address |
| mem_rdata | input | 8 | Memory read data, one cycle after the address |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | Memory write enable |
| issue | output | 1 | Next instruction may start |
| pc_load | output | 1 | Load `pc_vec` into the program counter |
| pc_vec | output | 16 | Handler or reset address |
| status | output | 8 | Status byte |
| sp | output | 8 | Stack pointer |

## Verification
A vector table sweeps the boundary decision across combinations of NMI edge, IRQ level and status byte. This separates "nothing pending", "IRQ masked", "IRQ taken", "NMI through the mask" and "NMI over IRQ", and each entry is checked for its vector, cycle count and the three stacked bytes. Directed tests contrast CLI with an active IRQ, CLI followed by the 0x40 opcode, and CLI before the IRQ rises, which tells deferral apart from immediate entry. Further tests hold NMI low to show it is taken once, run resets with the decimal bit both set and clear, drop an NMI edge through reset, hold bus request with and without a pending request, and do push/pull round trips that expose the decrement-then/increment-first ordering.

// File: rtl/ivs_pkg.sv
// Shared constants and sequencer state encoding for the interrupt entry
// and reset vector sequencer. Assumes a 16-bit address, 8-bit data space.
package ivs_pkg;
    localparam int AW = 16;
    localparam int DW = 8;

    localparam logic [AW-1:0] VEC_NMI   = 16'hFFFA;
    localparam logic [AW-1:0] VEC_RESET = 16'hFFFC;
    localparam logic [AW-1:0] VEC_IRQ   = 16'hFFFE;

    localparam logic [DW-1:0] STACK_PAGE = 8'h01;
    localparam logic [DW-1:0] SP_RESET   = 8'hFD;

    localparam int BIT_I = 2;
    localparam int BIT_D = 3;
    localparam logic [DW-1:0] MASK_D   = 8'h08;
    localparam logic [DW-1:0] MASK_B   = 8'h10;
    localparam logic [DW-1:0] MASK_U   = 8'h20;
    localparam logic [DW-1:0] P_RESET  = 8'h36;

    localparam logic [DW-1:0] OPC_RTI = 8'h40;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DUMMY,
        ST_PUSH_HI,
        ST_PUSH_LO,
        ST_PUSH_P,
        ST_VEC_LO,
        ST_VEC_HI,
        ST_LOAD
    } seq_state_t;
endpackage

// File: rtl/ivs_int_sense.sv
// Interrupt input conditioning: samples the IRQ level and latches NMI
// falling edges until the sequencer acknowledges them.
// Assumes both request lines are already synchronous to clk.
module ivs_int_sense (
    input  logic clk,
    input  logic rst_n,
    input  logic irq_n,
    input  logic nmi_n,
    input  logic nmi_ack,
    output logic nmi_pend,
    output logic irq_act
);
    logic nmi_q;
    logic nmi_fall;

    assign nmi_fall = nmi_q & ~nmi_n;

    // Track the NMI line, hold any falling edge, register the IRQ level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            nmi_q    <= 1'b1;
            nmi_pend <= 1'b0;
            irq_act  <= 1'b0;
        end else begin
            nmi_q    <= nmi_n;
            nmi_pend <= nmi_fall | (nmi_pend & ~nmi_ack);
            irq_act  <= ~irq_n;
        end
    end
endmodule

// File: rtl/ivs_stack.sv
// Stack pointer with fixed-page address generation. Push uses the current
// pointer then decrements; pull uses pointer+1 and increments.
// Assumes dec and inc are never requested in the same cycle.
module ivs_stack #(
    parameter int              W       = 8,
    parameter logic [W-1:0]    PAGE    = 8'h01,
    parameter logic [W-1:0]    SP_INIT = 8'hFD
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           dec,
    input  logic           inc,
    output logic [W-1:0]   sp,
    output logic [2*W-1:0] push_addr,
    output logic [2*W-1:0] pull_addr
);
    logic [W-1:0] sp_up;

    assign sp_up     = sp + 1'b1;
    assign push_addr = {PAGE, sp};
    assign pull_addr = {PAGE, sp_up};

    // Move the pointer one step per push or pull.
    always_ff @(posedge clk) begin
        if (!rst_n)   sp <= SP_INIT;
        else if (dec) sp <= sp - 1'b1;
        else if (inc) sp <= sp_up;
    end
endmodule

// File: rtl/ivs_status.sv
// Status byte holder. Reset forces the fixed pattern but keeps the decimal
// bit; the core may overwrite the byte; CLI clears and entry sets the mask.
// Assumes wr_en, cli and set_i are not raised together except wr_en wins.
module ivs_status
    import ivs_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          cli,
    input  logic          set_i,
    output logic [DW-1:0] p
);
    // Update the status byte from reset, core writes or mask changes.
    always_ff @(posedge clk) begin
        if (!rst_n)      p <= P_RESET | (p & MASK_D);
        else if (wr_en)  p <= wr_data;
        else if (cli)    p[BIT_I] <= 1'b0;
        else if (set_i)  p[BIT_I] <= 1'b1;
    end
endmodule

// File: rtl/irqvec_sequencer.sv
// Reset, NMI and IRQ entry sequencer for an 8-bit core. Decides at each
// instruction boundary between issuing and entering an interrupt, runs the
// 7-cycle entry (dummy, three pushes, two vector reads, load) and the reset
// vector fetch, and serves single-byte core pushes and pulls.
// Assumes: memory read data arrives one cycle after its address; the core
// holds pc_cur stable during entry and only requests stack operations while
// not at a boundary.
module irqvec_sequencer
    import ivs_pkg::*;
#(
    parameter logic [DW-1:0] SP_INIT = SP_RESET
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          irq_n,
    input  logic          nmi_n,
    input  logic          busreq,
    input  logic          boundary,
    input  logic          cli_exec,
    input  logic [DW-1:0] next_op,
    input  logic [AW-1:0] pc_cur,
    input  logic          p_we,
    input  logic [DW-1:0] p_wdata,
    input  logic          stk_push,
    input  logic          stk_pull,
    input  logic [DW-1:0] stk_wdata,
    output logic [AW-1:0] mem_addr,
    input  logic [DW-1:0] mem_rdata,
    output logic [DW-1:0] mem_wdata,
    output logic          mem_we,
    output logic          issue,
    output logic          pc_load,
    output logic [AW-1:0] pc_vec,
    output logic [DW-1:0] status,
    output logic [DW-1:0] sp
);
    seq_state_t    state;
    logic [AW-1:0] vec_base;
    logic [DW-1:0] vec_lo;
    logic          after_cli;
    logic          nmi_pend, irq_act;
    logic          idle, decide, want_nmi, want_irq, take;
    logic          core_push, core_pull, sp_dec;
    logic [AW-1:0] push_addr, pull_addr;

    ivs_int_sense u_sense (
        .clk      (clk),
        .rst_n    (rst_n),
        .irq_n    (irq_n),
        .nmi_n    (nmi_n),
        .nmi_ack  (decide & want_nmi),
        .nmi_pend (nmi_pend),
        .irq_act  (irq_act)
    );

    ivs_status u_status (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (p_we),
        .wr_data (p_wdata),
        .cli     (cli_exec),
        .set_i   (state == ST_PUSH_P),
        .p       (status)
    );

    ivs_stack #(
        .W       (DW),
        .PAGE    (STACK_PAGE),
        .SP_INIT (SP_INIT)
    ) u_stack (
        .clk       (clk),
        .rst_n     (rst_n),
        .dec       (sp_dec),
        .inc       (core_pull),
        .sp        (sp),
        .push_addr (push_addr),
        .pull_addr (pull_addr)
    );

    // Boundary decision: NMI first, then an unmasked, undeferred IRQ.
    assign idle      = (state == ST_IDLE);
    assign decide    = idle & boundary & ~busreq;
    assign want_nmi  = nmi_pend;
    assign want_irq  = irq_act & ~status[BIT_I] & ~after_cli;
    assign take      = decide & (want_nmi | want_irq);
    assign issue     = decide & ~take;
    assign core_push = idle & stk_push;
    assign core_pull = idle & ~stk_push & stk_pull;
    assign sp_dec    = core_push | (state == ST_PUSH_HI) |
                       (state == ST_PUSH_LO) | (state == ST_PUSH_P);
    assign pc_load   = (state == ST_LOAD);
    assign pc_vec    = {mem_rdata, vec_lo};

    // One-instruction deferral armed by CLI, dropped at the next decision.
    always_ff @(posedge clk) begin
        if (!rst_n)        after_cli <= 1'b0;
        else if (cli_exec) after_cli <= irq_act & status[BIT_I] & (next_op != OPC_RTI);
        else if (decide)   after_cli <= 1'b0;
    end

    // Sequencer state, selected vector and captured vector low byte.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_VEC_LO;
            vec_base <= VEC_RESET;
            vec_lo   <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (take) begin
                        state    <= ST_DUMMY;
                        vec_base <= want_nmi ? VEC_NMI : VEC_IRQ;
                    end
                end
                ST_DUMMY:   state <= ST_PUSH_HI;
                ST_PUSH_HI: state <= ST_PUSH_LO;
                ST_PUSH_LO: state <= ST_PUSH_P;
                ST_PUSH_P:  state <= ST_VEC_LO;
                ST_VEC_LO:  state <= ST_VEC_HI;
                ST_VEC_HI: begin
                    state  <= ST_LOAD;
                    vec_lo <= mem_rdata;
                end
                default:    state <= ST_IDLE;
            endcase
        end
    end

    // Memory port steering for every sequencer state and core stack access.
    always_comb begin
        mem_addr  = pc_cur;
        mem_wdata = '0;
        mem_we    = 1'b0;
        case (state)
            ST_PUSH_HI: begin
                mem_addr  = push_addr;
                mem_wdata = pc_cur[AW-1:DW];
                mem_we    = 1'b1;
            end
            ST_PUSH_LO: begin
                mem_addr  = push_addr;
                mem_wdata = pc_cur[DW-1:0];
                mem_we    = 1'b1;
            end
            ST_PUSH_P: begin
                mem_addr  = push_addr;
                mem_wdata = (status | MASK_U) & ~MASK_B;
                mem_we    = 1'b1;
            end
            ST_VEC_LO: mem_addr = vec_base;
            ST_VEC_HI: mem_addr = {vec_base[AW-1:1], 1'b1};
            ST_IDLE: begin
                if (core_push) begin
                    mem_addr  = push_addr;
                    mem_wdata = stk_wdata;
                    mem_we    = 1'b1;
                end else if (core_pull) begin
                    mem_addr = pull_addr;
                end
            end
            default: mem_addr = pc_cur;
        endcase
    end
endmodule

// File: rtl/ivs_checker.sv
// Temporal checks on the sequencer ports; attached by bind below.
// Assumes the synchronous active-low reset of the design.
module ivs_checker
    import ivs_pkg::*;
(
    input logic          clk,
    input logic          rst_n,
    input logic          busreq,
    input logic          issue,
    input logic          mem_we,
    input logic [AW-1:0] mem_addr,
    input logic          pc_load,
    input logic [DW-1:0] status,
    input logic [DW-1:0] sp
);
    assert_reset_state_R1: assert property (@(posedge clk)
        !rst_n |=> (sp == SP_RESET) && ((status & ~MASK_D) == P_RESET));

    assert_vec_odd_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> ($past(mem_addr[AW-1:3]) == 13'h1FFF) && $past(mem_addr[0]));

    assert_load_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !pc_load);

    assert_stack_page_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_addr[AW-1:DW] == STACK_PAGE));

    assert_mask_on_load_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load && $past(mem_we, 3) |-> status[BIT_I]);

    assert_busreq_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        busreq |-> !issue);

    assert_push_dec_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> (sp == $past(sp) - 8'd1));
endmodule

bind irqvec_sequencer ivs_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .busreq   (busreq),
    .issue    (issue),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .pc_load  (pc_load),
    .status   (status),
    .sp       (sp)
);

// File: tb/irqvec_sequencer_tb.sv
module irqvec_sequencer_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        irq_n = 1'b1, nmi_n = 1'b1, busreq = 1'b0, boundary = 1'b0;
    logic        cli_exec = 1'b0, p_we = 1'b0, stk_push = 1'b0, stk_pull = 1'b0;
    logic [7:0]  next_op = 8'hEA, p_wdata = 8'h00, stk_wdata = 8'h00;
    logic [15:0] pc_cur = 16'h4321;
    logic [15:0] mem_addr, pc_vec;
    logic [7:0]  mem_rdata = 8'h00, mem_wdata, status, sp;
    logic        mem_we, issue, pc_load;
    logic [7:0]  stack_mem [256];
    int          checks = 0, errors = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    irqvec_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n), .busreq(busreq),
        .boundary(boundary), .cli_exec(cli_exec), .next_op(next_op), .pc_cur(pc_cur),
        .p_we(p_we), .p_wdata(p_wdata), .stk_push(stk_push), .stk_pull(stk_pull),
        .stk_wdata(stk_wdata), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
        .mem_wdata(mem_wdata), .mem_we(mem_we), .issue(issue), .pc_load(pc_load),
        .pc_vec(pc_vec), .status(status), .sp(sp)
    );

    // Memory model: vectors at the top, a stack page, filler elsewhere.
    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        case (a)
            16'hFFFA: return 8'h34;
            16'hFFFB: return 8'h12;
            16'hFFFC: return 8'h00;
            16'hFFFD: return 8'h80;
            16'hFFFE: return 8'hCD;
            16'hFFFF: return 8'hAB;
            default:  return (a[15:8] == 8'h01) ? stack_mem[a[7:0]] : (a[15:8] ^ a[7:0]);
        endcase
    endfunction

    always @(posedge clk) begin
        mem_rdata <= mem_byte(mem_addr);
        if (mem_we && mem_addr[15:8] == 8'h01) stack_mem[mem_addr[7:0]] <= mem_wdata;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Poll from the cycle after a decision until pc_load; returns cycle count.
    task automatic wait_load(output int n);
        n = 0;
        do begin
            @(negedge clk);
            boundary = 1'b0;
            n++;
        end while (!pc_load && n < 20);
    endtask

    task automatic do_reset();
        int n;
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        wait_load(n);
        chk("R2 reset fetch cycles", n, 2);
        chk("R2 reset vector", pc_vec, 16'h8000);
        @(negedge clk);
    endtask

    task automatic write_p(input logic [7:0] v);
        @(negedge clk); p_we = 1'b1; p_wdata = v;
        @(negedge clk); p_we = 1'b0;
    endtask

    // Enter an interrupt from the current negedge with boundary driven.
    task automatic check_entry(input string req, input logic [15:0] vec,
                               input logic [7:0] p_before);
        int n;
        logic [7:0] s0;
        s0 = sp;
        #2 chk({req, " no issue on entry"}, issue, 0);
        wait_load(n);
        chk({req, " entry cycles R5"}, n, 7);
        chk({req, " vector"}, pc_vec, vec);
        @(negedge clk);
        chk({req, " sp R5"}, sp, s0 - 8'd3);
        chk({req, " pch R5"}, stack_mem[s0], 8'h43);
        chk({req, " pcl R5"}, stack_mem[s0 - 8'd1], 8'h21);
        chk({req, " pushed P R5"}, stack_mem[s0 - 8'd2], (p_before | 8'h20) & 8'hEF);
        chk({req, " mask set R5"}, status, p_before | 8'h04);
    endtask

    // Table: {nmi pulse, irq level, status, kind 0=issue 1=NMI 2=IRQ}
    localparam int NV = 7;
    localparam logic [11:0] VEC_TAB [NV] = '{
        {1'b0, 1'b0, 8'hC3, 2'd0},
        {1'b0, 1'b1, 8'hC7, 2'd0},
        {1'b0, 1'b1, 8'hC3, 2'd2},
        {1'b1, 1'b0, 8'hC7, 2'd1},
        {1'b1, 1'b1, 8'hC3, 2'd1},
        {1'b0, 1'b1, 8'h00, 2'd2},
        {1'b1, 1'b1, 8'hFF, 2'd1}
    };

    initial begin
        logic [7:0] s0;
        for (int i = 0; i < 256; i++) stack_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        begin
            int n;
            wait_load(n);
            chk("R2 first reset cycles", n, 2);
            chk("R2 first reset vector", pc_vec, 16'h8000);
        end
        @(negedge clk);
        chk("R1 status after reset", status & 8'hF7, 8'h36);
        chk("R1 sp after reset", sp, 8'hFD);
        chk("R10 no issue without boundary", issue, 0);

        // Table walk over boundary decisions (R3, R4, R5, R10)
        for (int i = 0; i < NV; i++) begin
            logic [11:0] e;
            e = VEC_TAB[i];
            @(negedge clk); p_we = 1'b1; p_wdata = e[9:2];
            irq_n = ~e[10];
            if (e[11]) nmi_n = 1'b0;
            @(negedge clk); p_we = 1'b0; nmi_n = 1'b1;
            chk("R11 status write", status, e[9:2]);
            @(negedge clk); boundary = 1'b1;
            if (e[1:0] == 2'd0) begin
                #2 chk("R3 R10 issue when nothing to take", issue, 1);
                @(negedge clk); boundary = 1'b0;
            end else begin
                check_entry(e[1:0] == 2'd1 ? "R4 NMI" : "R3 IRQ",
                            e[1:0] == 2'd1 ? 16'h1234 : 16'hABCD, e[9:2]);
            end
        end
        irq_n = 1'b1;

        // R4: NMI held low is taken once
        write_p(8'h04);
        nmi_n = 1'b0;
        @(negedge clk); @(negedge clk); boundary = 1'b1;
        check_entry("R4 held NMI", 16'h1234, 8'h04);
        boundary = 1'b1;
        #2 chk("R4 held NMI not retaken", issue, 1);
        @(negedge clk); boundary = 1'b0; nmi_n = 1'b1;

        // R1: decimal bit kept across reset, NMI latch cleared by reset
        write_p(8'hFF);
        do_reset();
        chk("R1 reset keeps D set", status, 8'h3E);
        write_p(8'h00);
        nmi_n = 1'b0;
        @(negedge clk); nmi_n = 1'b1;
        do_reset();
        chk("R1 reset keeps D clear", status, 8'h36);
        chk("R1 sp reset", sp, 8'hFD);
        boundary = 1'b1;
        #2 chk("R1 NMI latch cleared by reset", issue, 1);
        @(negedge clk); boundary = 1'b0;

        // R6: CLI with active IRQ defers by one instruction
        irq_n = 1'b0;
        @(negedge clk); next_op = 8'hEA; cli_exec = 1'b1;
        @(negedge clk); cli_exec = 1'b0;
        chk("R6 CLI clears mask", status[2], 0);
        boundary = 1'b1;
        #2 chk("R6 one instruction issued after CLI", issue, 1);
        @(negedge clk);
        check_entry("R6 deferred IRQ", 16'hABCD, 8'h32);
        irq_n = 1'b1;

        // R7: CLI followed by return-from-interrupt opcode, no deferral
        irq_n = 1'b0;
        @(negedge clk); next_op = 8'h40; cli_exec = 1'b1;
        @(negedge clk); cli_exec = 1'b0; next_op = 8'hEA; boundary = 1'b1;
        check_entry("R7 IRQ right after CLI before RTI", 16'hABCD, 8'h32);
        irq_n = 1'b1;

        // R6: CLI with IRQ inactive, later IRQ taken at first boundary
        @(negedge clk); cli_exec = 1'b1;
        @(negedge clk); cli_exec = 1'b0; irq_n = 1'b0;
        @(negedge clk); boundary = 1'b1;
        check_entry("R6 no deferral without IRQ at CLI", 16'hABCD, 8'h32);
        irq_n = 1'b1;

        // R8: bus request holds off issue and entry
        write_p(8'h00);
        busreq = 1'b1; boundary = 1'b1;
        #2 chk("R8 no issue under busreq", issue, 0);
        irq_n = 1'b0;
        s0 = sp;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            #2 chk("R8 no issue under busreq", issue, 0);
            chk("R8 no write under busreq", mem_we, 0);
            chk("R8 no load under busreq", pc_load, 0);
        end
        chk("R8 sp unchanged under busreq", sp, s0);
        @(negedge clk); busreq = 1'b0;
        check_entry("R8 entry after busreq", 16'hABCD, 8'h00);
        irq_n = 1'b1;

        // R9: core push and pull ordering
        s0 = sp;
        @(negedge clk); stk_push = 1'b1; stk_wdata = 8'h5A;
        #2 chk("R9 push address", mem_addr, {8'h01, s0});
        @(negedge clk); stk_wdata = 8'hA5;
        chk("R9 sp after push", sp, s0 - 8'd1);
        @(negedge clk); stk_push = 1'b0;
        chk("R9 sp after two pushes", sp, s0 - 8'd2);
        chk("R9 first byte stored", stack_mem[s0], 8'h5A);
        stk_pull = 1'b1;
        #2 chk("R9 pull address", mem_addr, {8'h01, s0 - 8'd1});
        @(negedge clk);
        chk("R9 pull data", mem_rdata, 8'hA5);
        chk("R9 sp after pull", sp, s0 - 8'd1);
        @(negedge clk); stk_pull = 1'b0;
        chk("R9 second pull data", mem_rdata, 8'h5A);
        chk("R9 sp restored", sp, s0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #2000000;
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule